// File: doc/BRIEF.md
# Register-mapped GPIO port with control registers

This block is a slave on a simple synchronous register bus. It holds eight 16-bit control words and a 16-line general-purpose port. The control words are a mode word, a clock divider, a read-only status word, a power word, a card-control word and three interrupt words (request, mask, status). The port has a direction register and a level register. Nothing in the block acts on the control words. They are plain storage, apart from the power word, which sets extra bits when it is written.

The driven output word is the level register masked by the direction register. It is recomputed only when software writes the direction or the level register. Each of the 16 input lines passes through a two-flop synchronizer. When its synchronized value changes, it updates its own bit of the level register. The driven outputs do not follow the inputs until the next direction or level write.

Top module: `gpio_ctrl_regs`

## Requirements
- R1: Only address bits [5:0] are decoded, so an address of 0x40 plus an offset reaches the same register as the bare offset.
- R2: Offsets: mode 0x00, divider 0x04, status 0x08, power 0x0C, card 0x10, irq request 0x14, irq mask 0x18, irq status 0x1C, direction 0x20, level 0x24 and 0x28. Write data is cut to bits [15:0] before it is stored, and each storage register reads back its stored value.
- R3: A write to power stores the value. When bit 7 of the written value is 1, bits 15 and 6 are also set (the stored value is OR-ed with 0x8040).
- R4: Status reads 0x0002 after reset, and writes to 0x08 leave it unchanged.
- R5: A write to 0x24 or 0x28 stores the data AND-ed with the current direction register. A read of either offset returns the level register.
- R6: The output word gpio_out equals level AND direction. It changes only on the clock edge that stores a direction or level write, and it is valid from that edge.
- R7: When the synchronized value of an input line changes, that value is copied into the line's level bit on the third rising edge after the change, whatever the direction. This does not change gpio_out.
- R8: When a bus write to the level register lands on the same edge as an input-driven update, the bus write wins for every bit.
- R9: A read of an undecoded offset returns 0. A write to one changes no register.
- R10: A synchronous active-high reset clears every register except status, clears the synchronizer, and drives gpio_out to 0.
- R11: rd_data is registered: it carries the addressed value in the cycle after rd_en is high and is 0 in the cycle after rd_en is low. Bits above 15 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address; bits [5:0] decoded |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data; bits [15:0] used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | BUS_W | Registered read data |
| gpio_in | input | 16 | Asynchronous input lines |
| gpio_out | output | 16 | Driven output lines |

## Verification
A table of write-then-read pairs covers every offset. It includes the power write with bit 7 set and with bit 7 clear, so the side effect is told apart from plain storage. It also covers aliased addresses above 0x3F and undecoded offsets, which show whether decoding is limited to six bits and whether stray writes leak into other registers. Directed port sequences follow. A level write under a partial direction mask exposes a missing AND. Input changes on undriven lines prove that the level bits update while the outputs stay put. An input change timed to land on the same edge as a level write shows which source wins.

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  output logic [BUS_W-1:0]  rd_data,
  input  logic [15:0]       gpio_in,
  output logic [15:0]       gpio_out
);
  localparam int W = 16;
  localparam logic [5:0] A_MODE = 6'h00, A_DIV = 6'h04, A_STAT = 6'h08,
                         A_PWR = 6'h0C, A_CARD = 6'h10, A_IRQ = 6'h14,
                         A_MASK = 6'h18, A_IST = 6'h1C, A_DIR = 6'h20,
                         A_LVW = 6'h24, A_LVR = 6'h28;
  localparam logic [W-1:0] STAT_INIT = 16'h0002;

  logic [5:0]   off;
  logic [W-1:0] wv;
  logic [W-1:0] mode, div, status, power, card, irq, mask, ist, dir, level, drv;
  logic [W-1:0] in_s1, in_s2, in_s3, in_chg;
  logic         wr_lvl, wr_dir;
  logic [W-1:0] rd_mux;

  assign off    = addr[5:0];
  assign wv     = wr_data[W-1:0];
  assign wr_lvl = wr_en && (off == A_LVW || off == A_LVR);
  assign wr_dir = wr_en && (off == A_DIR);
  assign in_chg = in_s2 ^ in_s3;
  assign gpio_out = drv;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0; div <= '0; power <= '0; card <= '0;
      irq <= '0; mask <= '0; ist <= '0;
      status <= STAT_INIT;
    end else if (wr_en) begin
      case (off)
        A_MODE: mode  <= wv;
        A_DIV:  div   <= wv;
        A_PWR:  power <= wv[7] ? (wv | 16'h8040) : wv;
        A_CARD: card  <= wv;
        A_IRQ:  irq   <= wv;
        A_MASK: mask  <= wv;
        A_IST:  ist   <= wv;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_s1 <= '0; in_s2 <= '0; in_s3 <= '0;
    end else begin
      in_s1 <= gpio_in; in_s2 <= in_s1; in_s3 <= in_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir <= '0; level <= '0; drv <= '0;
    end else begin
      if (wr_dir) dir <= wv;
      if (wr_lvl) level <= wv & dir;
      else        level <= (level & ~in_chg) | (in_s2 & in_chg);
      if (wr_dir)      drv <= level & wv;
      else if (wr_lvl) drv <= wv & dir;
    end
  end

  always_comb begin
    case (off)
      A_MODE:       rd_mux = mode;
      A_DIV:        rd_mux = div;
      A_STAT:       rd_mux = status;
      A_PWR:        rd_mux = power;
      A_CARD:       rd_mux = card;
      A_IRQ:        rd_mux = irq;
      A_MASK:       rd_mux = mask;
      A_IST:        rd_mux = ist;
      A_DIR:        rd_mux = dir;
      A_LVW, A_LVR: rd_mux = level;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= BUS_W'(rd_mux);
    else            rd_data <= '0;
  end
endmodule

// File: rtl/gpio_ctrl_regs_chk.sv
module gpio_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [BUS_W-1:0]  wr_data,
  input logic              rd_en,
  input logic [BUS_W-1:0]  rd_data,
  input logic [15:0]       gpio_out,
  input logic [15:0]       power,
  input logic [15:0]       dir
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) p_out_low_reset_r10: assert (gpio_out == 16'h0);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(gpio_out));

  p_out_in_dir_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((gpio_out & ~dir) == 16'h0));

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> (rd_data == '0));

  p_status_read_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(addr[5:0]) == 6'h08) |-> (rd_data == BUS_W'(16'h0002)));

  p_power_bits_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(addr[5:0]) == 6'h0C && $past(wr_data[7]))
      |-> (power[15] && power[6]));
endmodule

bind gpio_ctrl_regs gpio_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .gpio_out(gpio_out), .power(power), .dir(dir)
);

// File: tb/gpio_ctrl_regs_tb.sv
`timescale 1ns/1ps
module gpio_ctrl_regs_tb;
  localparam int ADDR_W = 8;
  localparam int BUS_W  = 32;
  localparam int NV     = 15;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [BUS_W-1:0]  wr_data = '0;
  logic              rd_en = 1'b0;
  logic [BUS_W-1:0]  rd_data;
  logic [15:0]       gpio_in = '0;
  logic [15:0]       gpio_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .gpio_in(gpio_in), .gpio_out(gpio_out)
  );

  // {address, write data, expected read-back}
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 32'h1234ABCD, 16'hABCD},  // R2 truncation
    {8'h04, 32'hFFFF0055, 16'h0055},  // R2
    {8'h0C, 32'h00000080, 16'h80C0},  // R3 bit 7 set
    {8'h0C, 32'h00000041, 16'h0041},  // R3 bit 7 clear
    {8'h0C, 32'h0001FF7F, 16'hFF7F},  // R3
    {8'h10, 32'h00005A5A, 16'h5A5A},  // R2
    {8'h14, 32'h00000001, 16'h0001},  // R2
    {8'h18, 32'h0000FFFF, 16'hFFFF},  // R2
    {8'h1C, 32'h00008001, 16'h8001},  // R2
    {8'h08, 32'h0000FFFF, 16'h0002},  // R4 read only
    {8'h4C, 32'h00000180, 16'h81C0},  // R1 alias of power
    {8'h40, 32'h00007777, 16'h7777},  // R1 alias of mode
    {8'h2C, 32'h00001111, 16'h0000},  // R9
    {8'h01, 32'h00002222, 16'h0000},  // R9
    {8'h3F, 32'h00003333, 16'h0000}   // R9
  };

  task automatic check(input string req, input logic [BUS_W-1:0] got, input logic [BUS_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [BUS_W-1:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  initial begin
    logic [BUS_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    check("R10 gpio_out after reset", BUS_W'(gpio_out), 0);
    bus_rd(8'h08, v); check("R4 status reset", v, 32'h0002);
    bus_rd(8'h00, v); check("R10 mode reset", v, 0);
    @(negedge clk); check("R11 idle rd_data", rd_data, 0);

    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i][55:48], VEC[i][47:16]);
      bus_rd(VEC[i][55:48], v);
      check($sformatf("R2 vector %0d", i), v, BUS_W'(VEC[i][15:0]));
    end
    bus_rd(8'h00, v); check("R1 R9 mode via alias, untouched by stray writes", v, 32'h7777);
    check("R6 no output change from control writes", BUS_W'(gpio_out), 0);

    bus_wr(8'h20, 32'h000000FF);
    check("R6 dir write with zero level", BUS_W'(gpio_out), 0);
    bus_wr(8'h24, 32'h0000F0F0);
    check("R6 output after level write", BUS_W'(gpio_out), 32'h00F0);
    bus_rd(8'h28, v); check("R5 level masked by dir", v, 32'h00F0);
    bus_rd(8'h68, v); check("R1 aliased level read", v, 32'h00F0);

    @(negedge clk); gpio_in = 16'h0F00;
    repeat (5) @(negedge clk);
    check("R7 output unchanged by inputs", BUS_W'(gpio_out), 32'h00F0);
    bus_rd(8'h24, v); check("R7 inputs land in level", v, 32'h0FF0);
    bus_wr(8'h20, 32'h00000FFF);
    check("R6 dir write recomputes output", BUS_W'(gpio_out), 32'h0FF0);

    // R8: the input change reaches level on the same edge as the bus write
    @(negedge clk); gpio_in = 16'h2F00;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 8'h28; wr_data = 32'h0; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    check("R6 output after clearing level", BUS_W'(gpio_out), 0);
    repeat (5) @(negedge clk);
    bus_rd(8'h24, v); check("R8 bus write wins", v, 0);

    gpio_in = 16'h0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 output cleared by reset", BUS_W'(gpio_out), 0);
    bus_rd(8'h0C, v); check("R10 power cleared", v, 0);
    bus_rd(8'h20, v); check("R10 dir cleared", v, 0);
    bus_rd(8'h28, v); check("R10 level cleared", v, 0);
    bus_rd(8'h08, v); check("R4 status survives reset", v, 32'h0002);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule